// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block accepts one interrupt delivery request at a time and turns it into per-processor inject strobes. A request carries a destination ID, a flag that selects physical or logical addressing, a delivery mode, a vector and a trigger-mode bit. From per-processor presence flags, physical IDs and logical IDs it forms the set of target processors. It then dispatches the vector to that set.

In fixed mode every target receives the vector. The targets are served one per cycle, lowest index first, and the block reports itself busy and refuses new requests until the walk ends. In lowest-priority mode a single target is chosen from the set by a rotating pointer. Any other delivery mode is dropped without effect, and so is any request whose target set is empty.

Top module: `irq_dispatch`

## Requirements
- R1: In physical mode (`req_logical`=0), destination 0xFF selects every present processor.
- R2: In physical mode, any other destination selects only the lowest-indexed present processor whose physical ID equals the destination, so at most one target.
- R3: In logical mode (`req_logical`=1), a destination of zero gives an empty target set.
- R4: In logical mode, a nonzero destination selects every present processor whose logical ID shares at least one set bit with the destination.
- R5: A request with an empty target set produces no strobe and does not raise `busy`.
- R6: Delivery mode 3'd0 (fixed) strobes each target once, one per cycle in ascending index order. The first strobe appears in the cycle after acceptance, and `inj_vec`/`inj_level` carry the request's vector and trigger bit. `inj_strobe` never has more than one bit set.
- R7: Delivery mode 3'd1 (lowest priority) strobes exactly one target in the cycle after acceptance. The target is the first member of the set found by searching upward from the index after the last chosen target, wrapping to 0. After reset the search starts at index 0.
- R8: Delivery mode codes other than 3'd0 and 3'd1 are dropped: no strobe, no `busy`, and the rotating pointer does not move.
- R9: `busy` is high exactly while fixed-mode strobes remain to be sent after the current one. `req_ready` is the inverse of `busy`, and a request presented while busy is ignored.
- R10: After reset, `inj_strobe` is zero, `busy` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request is accepted this cycle if valid |
| req_dest | input | ID_W | Destination ID |
| req_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| req_dmode | input | 3 | Delivery mode: 0 fixed, 1 lowest priority, others dropped |
| req_vec | input | VEC_W | Vector to deliver |
| req_level | input | 1 | Trigger mode forwarded with the vector |
| cpu_present | input | N_CPU | Per-processor presence flags |
| cpu_phys_id | input | N_CPU*ID_W | Physical IDs, processor i at bits [i*ID_W +: ID_W] |
| cpu_log_id | input | N_CPU*ID_W | Logical IDs, processor i at bits [i*ID_W +: ID_W] |
| inj_strobe | output | N_CPU | One-cycle inject strobe per processor |
| inj_vec | output | VEC_W | Vector accompanying the strobe |
| inj_level | output | 1 | Trigger mode accompanying the strobe |
| busy | output | 1 | A fixed-mode walk is in progress |

## Verification
The bench sweeps every presence pattern of four processors against physical destinations that include the broadcast value, a duplicated ID and an unmatched ID, and against logical destinations that include zero and multi-bit masks, in each delivery mode. A resolver that took the last matching physical ID, or every matching one, would strobe the wrong or extra processors. One that treated logical zero as "all" would dispatch where nothing is due. In the same sweep, a rotating pointer that failed to wrap, or that advanced on dropped modes, would pick a target that differs from the bench's own model. A mid-walk request is injected to show that a design that did not stall would corrupt the ascending strobe sequence or its vector.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] DMODE_FIXED  = 3'd0;
    localparam logic [MODE_W-1:0] DMODE_LOWEST = 3'd1;
endpackage

// File: rtl/irq_target_resolve.sv
module irq_target_resolve #(
    parameter int N_CPU = 4,
    parameter int ID_W  = 8
) (
    input  logic [ID_W-1:0]       dest,
    input  logic                  logical,
    input  logic [N_CPU-1:0]      present,
    input  logic [N_CPU*ID_W-1:0] phys_ids,
    input  logic [N_CPU*ID_W-1:0] log_ids,
    output logic [N_CPU-1:0]      tgt_mask
);
    logic found;
    logic bcast;

    assign bcast = (dest == {ID_W{1'b1}});

    always_comb begin
        tgt_mask = '0;
        found    = 1'b0;
        if (!logical) begin
            if (bcast) begin
                tgt_mask = present;
            end else begin
                for (int i = 0; i < N_CPU; i++) begin
                    if (!found && present[i] && (phys_ids[i*ID_W +: ID_W] == dest)) begin
                        tgt_mask[i] = 1'b1;
                        found       = 1'b1;
                    end
                end
            end
        end else if (dest != '0) begin
            for (int i = 0; i < N_CPU; i++) begin
                tgt_mask[i] = present[i] && (|(dest & log_ids[i*ID_W +: ID_W]));
            end
        end
    end
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int N_CPU = 4,
    localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic [N_CPU-1:0] cand,
    input  logic [IDX_W-1:0] last,
    output logic [N_CPU-1:0] pick_oh,
    output logic [IDX_W-1:0] pick_idx,
    output logic             pick_any
);
    int idx;

    always_comb begin
        pick_oh  = '0;
        pick_idx = '0;
        pick_any = 1'b0;
        idx      = 0;
        for (int k = 1; k <= N_CPU; k++) begin
            idx = int'(last) + k;
            if (idx >= N_CPU) idx = idx - N_CPU;
            if (!pick_any && cand[idx]) begin
                pick_any     = 1'b1;
                pick_oh[idx] = 1'b1;
                pick_idx     = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int ID_W  = 8,
    parameter int VEC_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ID_W-1:0]       req_dest,
    input  logic                  req_logical,
    input  logic [MODE_W-1:0]     req_dmode,
    input  logic [VEC_W-1:0]      req_vec,
    input  logic                  req_level,
    input  logic [N_CPU-1:0]      cpu_present,
    input  logic [N_CPU*ID_W-1:0] cpu_phys_id,
    input  logic [N_CPU*ID_W-1:0] cpu_log_id,
    output logic [N_CPU-1:0]      inj_strobe,
    output logic [VEC_W-1:0]      inj_vec,
    output logic                  inj_level,
    output logic                  busy
);
    localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

    typedef struct packed {
        logic [N_CPU-1:0] walk;
        logic [N_CPU-1:0] strobe;
        logic [VEC_W-1:0] vec;
        logic             level;
        logic [IDX_W-1:0] last;
    } disp_state_t;

    disp_state_t s_d, s_q;

    logic [N_CPU-1:0] tgt_mask;
    logic [N_CPU-1:0] rr_oh;
    logic [IDX_W-1:0] rr_idx;
    logic             rr_any;
    logic [N_CPU-1:0] low_walk;
    logic [N_CPU-1:0] low_tgt;
    logic             busy_q;

    irq_target_resolve #(.N_CPU(N_CPU), .ID_W(ID_W)) i_resolve (
        .dest     (req_dest),
        .logical  (req_logical),
        .present  (cpu_present),
        .phys_ids (cpu_phys_id),
        .log_ids  (cpu_log_id),
        .tgt_mask (tgt_mask)
    );

    irq_rr_pick #(.N_CPU(N_CPU)) i_rr (
        .cand     (tgt_mask),
        .last     (s_q.last),
        .pick_oh  (rr_oh),
        .pick_idx (rr_idx),
        .pick_any (rr_any)
    );

    // isolate the lowest set bit
    assign low_walk = s_q.walk & (~s_q.walk + N_CPU'(1));
    assign low_tgt  = tgt_mask & (~tgt_mask + N_CPU'(1));
    assign busy_q   = |s_q.walk;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = '0;
        if (busy_q) begin
            s_d.strobe = low_walk;
            s_d.walk   = s_q.walk & ~low_walk;
        end else if (req_valid) begin
            if (req_dmode == DMODE_FIXED && |tgt_mask) begin
                s_d.strobe = low_tgt;
                s_d.walk   = tgt_mask & ~low_tgt;
                s_d.vec    = req_vec;
                s_d.level  = req_level;
            end else if (req_dmode == DMODE_LOWEST && rr_any) begin
                s_d.strobe = rr_oh;
                s_d.last   = rr_idx;
                s_d.vec    = req_vec;
                s_d.level  = req_level;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.walk   <= '0;
            s_q.strobe <= '0;
            s_q.vec    <= '0;
            s_q.level  <= 1'b0;
            s_q.last   <= IDX_W'(N_CPU - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign inj_strobe = s_q.strobe;
    assign inj_vec    = s_q.vec;
    assign inj_level  = s_q.level;
    assign busy       = busy_q;
    assign req_ready  = !busy_q;

    // R2
    phys_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_logical && req_dest != {ID_W{1'b1}}) |-> ($countones(tgt_mask) <= 1));

    // R3
    log_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_logical && req_dest == '0) |=> (inj_strobe == '0 && !busy));

    // R6
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inj_strobe));

    // R7
    lowest_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_dmode == DMODE_LOWEST && |tgt_mask)
            |=> ($countones(inj_strobe) == 1 && !busy));

    // R8
    drop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_dmode != DMODE_FIXED && req_dmode != DMODE_LOWEST)
            |=> (inj_strobe == '0 && !busy));

    // R9
    walk_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(s_q.walk) == $countones($past(s_q.walk)) - 1
                  && inj_strobe != '0 && $stable(inj_vec)));
endmodule

// File: tb/test_irq_dispatch.sv
module test_irq_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [7:0]   req_dest = '0;
    logic         req_logical = 1'b0;
    logic [2:0]   req_dmode = '0;
    logic [7:0]   req_vec = '0;
    logic         req_level = 1'b0;
    logic [N-1:0] cpu_present = '0;
    logic [N*8-1:0] cpu_phys_id;
    logic [N*8-1:0] cpu_log_id;
    logic [N-1:0] inj_strobe;
    logic [7:0]   inj_vec;
    logic         inj_level;
    logic         busy;

    logic [7:0] phys_tab [0:N-1] = '{8'd5, 8'd7, 8'd5, 8'd9};
    logic [7:0] logi_tab [0:N-1] = '{8'h01, 8'h02, 8'h06, 8'h08};

    assign cpu_phys_id = {phys_tab[3], phys_tab[2], phys_tab[1], phys_tab[0]};
    assign cpu_log_id  = {logi_tab[3], logi_tab[2], logi_tab[1], logi_tab[0]};

    int n_checks = 0;
    int n_errors = 0;
    int rr_last  = N - 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dispatch #(.N_CPU(N), .ID_W(8), .VEC_W(8)) i_irq_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dest(req_dest), .req_logical(req_logical), .req_dmode(req_dmode),
        .req_vec(req_vec), .req_level(req_level), .cpu_present(cpu_present),
        .cpu_phys_id(cpu_phys_id), .cpu_log_id(cpu_log_id),
        .inj_strobe(inj_strobe), .inj_vec(inj_vec), .inj_level(inj_level), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_mask(logic [N-1:0] pres, logic [7:0] dest, logic logical);
        logic [N-1:0] m = '0;
        if (!logical) begin
            if (dest == 8'hFF) return pres;
            for (int i = 0; i < N; i++)
                if (pres[i] && phys_tab[i] == dest) return N'(1) << i;
        end else if (dest != 0) begin
            for (int i = 0; i < N; i++)
                if (pres[i] && (dest & logi_tab[i]) != 0) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic string sel_tag(logic [7:0] dest, logic logical);
        if (!logical) return (dest == 8'hFF) ? "R1" : "R2";
        return (dest == 0) ? "R3" : "R4";
    endfunction

    task automatic drive(input logic [N-1:0] pres, input logic [7:0] dest, input logic logical,
                         input logic [2:0] dmode, input logic [7:0] vec, input logic level);
        @(negedge clk);
        cpu_present = pres; req_dest = dest; req_logical = logical;
        req_dmode = dmode; req_vec = vec; req_level = level; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_req(input logic [N-1:0] pres, input logic [7:0] dest, input logic logical,
                           input logic [2:0] dmode, input logic [7:0] vec, input logic level);
        logic [N-1:0] m;
        logic [N-1:0] rem;
        logic [N-1:0] low;
        string st;
        int k;
        int pick;
        m  = model_mask(pres, dest, logical);
        st = sel_tag(dest, logical);
        drive(pres, dest, logical, dmode, vec, level);
        if (dmode == 3'd0 && m != 0) begin
            k = $countones(m);
            rem = m;
            for (int j = 0; j < k; j++) begin
                low = rem & (~rem + 4'd1);
                chk({"R6 strobe ", st}, int'(inj_strobe), int'(low));
                chk("R6 vec", int'(inj_vec), int'(vec));
                chk("R6 level", int'(inj_level), int'(level));
                chk("R9 busy", int'(busy), int'(j < k - 1));
                chk("R9 ready", int'(req_ready), int'(!(j < k - 1)));
                rem = rem & ~low;
                @(negedge clk);
            end
            chk("R6 end", int'(inj_strobe), 0);
        end else if (dmode == 3'd1 && m != 0) begin
            pick = -1;
            for (int o = 1; o <= N; o++) begin
                int ix = (rr_last + o) % N;
                if (pick < 0 && m[ix]) pick = ix;
            end
            rr_last = pick;
            chk({"R7 strobe ", st}, int'(inj_strobe), 1 << pick);
            chk("R7 vec", int'(inj_vec), int'(vec));
            chk("R7 busy", int'(busy), 0);
            @(negedge clk);
            chk("R7 end", int'(inj_strobe), 0);
        end else begin
            chk((dmode > 3'd1) ? "R8 strobe" : {"R5 strobe ", st}, int'(inj_strobe), 0);
            chk((dmode > 3'd1) ? "R8 busy" : "R5 busy", int'(busy), 0);
            @(negedge clk);
            chk("R5 quiet", int'(inj_strobe), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [7:0] plist [0:4] = '{8'd5, 8'd7, 8'd9, 8'd3, 8'hFF};
        logic [7:0] llist [0:7] = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h08, 8'h06, 8'h0C, 8'hFF};
        logic [2:0] mlist [0:2] = '{3'd0, 3'd1, 3'd5};
        logic [7:0] vec = 8'h20;
        repeat (3) @(negedge clk);
        chk("R10 strobe", int'(inj_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 strobe", int'(inj_strobe), 0);
        chk("R10 busy", int'(busy), 0);
        chk("R10 ready", int'(req_ready), 1);

        for (int p = 0; p < 16; p++) begin
            for (int d = 0; d < 13; d++) begin
                for (int mi = 0; mi < 3; mi++) begin
                    vec = vec + 8'd1;
                    if (d < 5) run_req(4'(p), plist[d], 1'b0, mlist[mi], vec, vec[0]);
                    else       run_req(4'(p), llist[d-5], 1'b1, mlist[mi], vec, vec[0]);
                end
            end
        end

        // R9: request presented mid-walk is ignored
        drive(4'hF, 8'hFF, 1'b0, 3'd0, 8'h55, 1'b1);
        chk("R9 first", int'(inj_strobe), 1);
        req_dest = 8'hFF; req_logical = 1'b0; req_dmode = 3'd1; req_vec = 8'hAA; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 stall s1", int'(inj_strobe), 2);
        chk("R9 stall vec", int'(inj_vec), 8'h55);
        @(negedge clk);
        chk("R9 stall s2", int'(inj_strobe), 4);
        @(negedge clk);
        chk("R9 stall s3", int'(inj_strobe), 8);
        chk("R9 stall busy", int'(busy), 0);
        @(negedge clk);
        chk("R9 no extra", int'(inj_strobe), 0);
        // pointer must not have moved
        run_req(4'hF, 8'hFF, 1'b0, 3'd1, 8'h77, 1'b0);
        // R8: dropped mode leaves pointer alone
        run_req(4'hF, 8'hFF, 1'b0, 3'd7, 8'h78, 1'b0);
        run_req(4'hF, 8'hFF, 1'b0, 3'd1, 8'h79, 1'b0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule